// File: doc/BRIEF.md
# Watchdog Toggle Timer Channel

This block is a single timer channel operating in a watchdog toggle mode, with its own down-counting prescaler. Software writes a start value and a match value and then enables the channel with the mode field set to the watchdog code. The count then climbs by one on every tick. A tick comes either from a divide-by-two of the system clock or from the prescaler. The prescaler is a 21-bit down-counter whose period is the programmed value plus one.

When the count reaches the match value, or wraps past its all-ones value, the channel records an event in a sticky status bit. It can raise a maskable interrupt, and it emits a one-cycle DMA request. On a wrap the count also restarts from the start value. The output pin stays undriven until the first event. From then on it drives a level chosen by an invert bit. When the channel stops running, the pin keeps driving for three more clocks, so that it can act as a reset source of valid length. A stop input freezes counting and releases the pin. A wait input changes nothing.

Top module: `wdog_toggle_timer`

## Requirements
- R1: Control bit 5 picks the tick: 0 gives one tick every two clocks, the first count step landing on the third clock edge after the enabling write; 1 gives one tick every P+1 clocks from the prescaler, where P is the prescale register (address 4).
- R2: The rising edge of "enabled in watchdog mode" loads the counter with the start value (address 2) on the next clock edge; each tick then adds one, and address 5 reads the count.
- R3: A tick that brings the count to the match value (address 3) sets status bit 0; irq_cmp_o equals status bit 0 AND control bit 7.
- R4: A tick at the all-ones count sets status bit 1 and reloads the start value, whatever the value of the reload control bit 9; irq_ovf_o equals status bit 1 AND control bit 8.
- R5: Writing 1 to a status bit at address 1 clears it; if an event for that bit occurs in the same cycle, the bit stays set.
- R6: pin_oe_o is 0 from enable until the first event; afterwards pin_o equals control bit 6 and pin_oe_o is 1 while running.
- R7: When the channel stops running, pin_oe_o stays 1 for the cycle in which that happens and for two more clock edges, then drops to 0.
- R8: dma_req_o is a one-cycle pulse on the clock edge that records each compare or wrap event.
- R9: Only mode value 10 in control bits 4:1 runs the channel; values 8, 11, 12, 13, 14 and 15 leave the count, flags and pin idle.
- R10: While stop_i is 1 the count holds and the pin is released as in R7; when stop_i falls, counting resumes; wait_i has no effect.
- R11: The prescaler is a 21-bit down-counter that runs only while the channel is running with the prescaler selected, reloads P on reaching zero, and restarts from P when idle.
- R12: After reset, all registers, the flags, the count, the pin enable, the interrupts and the DMA request are 0. Control bit 0 is the enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address: 0 control, 1 status, 2 start, 3 match, 4 prescale, 5 count |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data for addr_i, combinational |
| stop_i | input | 1 | Halts counting and releases the pin |
| wait_i | input | 1 | Low-power wait indication, no effect |
| irq_cmp_o | output | 1 | Compare interrupt request |
| irq_ovf_o | output | 1 | Wrap interrupt request |
| dma_req_o | output | 1 | One-cycle DMA request per event |
| pin_o | output | 1 | Pin drive value |
| pin_oe_o | output | 1 | Pin drive enable; 0 means high impedance |

## Verification
A software clear of a status bit and a new event on the same bit can fall in one cycle. The bench counts clock edges from the enabling write, so that its clear write lands exactly on the edge where the compare occurs. It then judges from the status read that the bit survived. A second clear, with no event that cycle, must read back zero.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
  localparam logic [ADDR_W-1:0] A_PRE  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CMP  = 3'd3;
  localparam logic [ADDR_W-1:0] A_PSC  = 3'd4;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd5;

  localparam logic [3:0] MODE_WDOG = 4'd10;

  // bit 0 = en, bits 4:1 = mode, 5 = src_psc, 6 = invert, 7 = cmp_ie, 8 = ovf_ie, 9 = reload
  typedef struct packed {
    logic       reload;
    logic       ovf_ie;
    logic       cmp_ie;
    logic       invert;
    logic       src_psc;
    logic [3:0] mode;
    logic       en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int PSC_W = 21
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [PSC_W-1:0] reload_i,
  output logic             tick_o
);
  logic [PSC_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (!run_i || tick_o)    cnt_q <= reload_i;
    else                          cnt_q <= cnt_q - 1'b1;
  end

  assign tick_o = run_i && (cnt_q == '0);

  AST_PSC_IDLE_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == $past(reload_i)); // R11
  AST_PSC_DECR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && $past(run_i) && !tick_o && !$past(tick_o) |=> cnt_q == $past(cnt_q) - 1'b1); // R11
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int DW    = 24,
  parameter int CNT_W = 24,
  parameter int PSC_W = 21
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              cmp_evt_i,
  input  logic              ovf_evt_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  preload_o,
  output logic [CNT_W-1:0]  compare_o,
  output logic [PSC_W-1:0]  psc_o,
  output logic [1:0]        flags_o,
  output logic [DW-1:0]     rdata_o
);
  logic [1:0] w1c;
  assign w1c = (wr_i && addr_i == A_STAT) ? wdata_i[1:0] : 2'b00;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o    <= '0;
      preload_o <= '0;
      compare_o <= '0;
      psc_o     <= '0;
    end else if (wr_i) begin
      case (addr_i)
        A_CTRL: ctrl_o    <= ctrl_t'(wdata_i[CTRL_W-1:0]);
        A_PRE:  preload_o <= wdata_i[CNT_W-1:0];
        A_CMP:  compare_o <= wdata_i[CNT_W-1:0];
        A_PSC:  psc_o     <= wdata_i[PSC_W-1:0];
        default: ;
      endcase
    end
  end

  // event wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_o <= '0;
    else         flags_o <= (flags_o & ~w1c) | {ovf_evt_i, cmp_evt_i};
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL: rdata_o[CTRL_W-1:0] = ctrl_o;
      A_STAT: rdata_o[1:0]        = flags_o;
      A_PRE:  rdata_o[CNT_W-1:0]  = preload_o;
      A_CMP:  rdata_o[CNT_W-1:0]  = compare_o;
      A_PSC:  rdata_o[PSC_W-1:0]  = psc_o;
      A_CNT:  rdata_o[CNT_W-1:0]  = cnt_i;
      default: rdata_o = '0;
    endcase
  end

  AST_FLAG_EVT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_evt_i |=> flags_o[0]); // R5
  AST_FLAG_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i == A_STAT && wdata_i[1] && !ovf_evt_i |=> !flags_o[1]); // R5
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] preload_i,
  input  logic [CNT_W-1:0] compare_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             cmp_evt_o,
  output logic             ovf_evt_o
);
  logic             wrap;
  logic [CNT_W-1:0] cnt_inc;

  assign wrap      = &cnt_o;
  assign cnt_inc   = cnt_o + 1'b1;
  assign ovf_evt_o = tick_i && !load_i && wrap;
  assign cmp_evt_o = tick_i && !load_i && !wrap && (cnt_inc == compare_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_o <= '0;
    else if (load_i)  cnt_o <= preload_i;
    else if (tick_i)  cnt_o <= wrap ? preload_i : cnt_inc;
  end

  AST_CNT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !load_i |=> $stable(cnt_o)); // R10
  AST_WRAP_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_evt_o |=> cnt_o == $past(preload_i)); // R4
  AST_CMP_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_evt_o |=> cnt_o == $past(compare_i)); // R3
  AST_LOAD_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_o == $past(preload_i)); // R2
endmodule

// File: rtl/wdog_pin.sv
module wdog_pin #(
  parameter int HOLD = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic live_i,
  input  logic clr_i,
  input  logic evt_i,
  input  logic invert_i,
  output logic oe_o,
  output logic pin_o
);
  localparam int HW = $clog2(HOLD + 1);

  logic [HW-1:0] hold_q;
  logic          armed_q;

  // reload while live, count down after release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             hold_q <= '0;
    else if (live_i)         hold_q <= HW'(HOLD);
    else if (hold_q != '0)   hold_q <= hold_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     armed_q <= 1'b0;
    else if (clr_i)  armed_q <= 1'b0;
    else if (evt_i)  armed_q <= 1'b1;
  end

  assign oe_o  = armed_q && (hold_q != '0);
  assign pin_o = invert_i;

  AST_PIN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(live_i) && armed_q |=> oe_o); // R7
  AST_PIN_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i && live_i |=> oe_o); // R6
  AST_PIN_FLOAT_ON_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !oe_o); // R6
endmodule

// File: rtl/wdog_toggle_timer.sv
module wdog_toggle_timer
  import wdog_pkg::*;
#(
  parameter int DW    = 24,
  parameter int CNT_W = 24,
  parameter int PSC_W = 21,
  parameter int HOLD  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic              stop_i,
  input  logic              wait_i,
  output logic              irq_cmp_o,
  output logic              irq_ovf_o,
  output logic              dma_req_o,
  output logic              pin_o,
  output logic              pin_oe_o
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] preload, compare, cnt;
  logic [PSC_W-1:0] psc_val;
  logic [1:0]       flags;
  logic             cmp_evt, ovf_evt;
  logic             active, active_q, live, load;
  logic             div_q, psc_run, psc_tick, tick;

  wdog_regs #(.DW(DW), .CNT_W(CNT_W), .PSC_W(PSC_W)) u_regs (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i,
    .cmp_evt_i(cmp_evt), .ovf_evt_i(ovf_evt), .cnt_i(cnt),
    .ctrl_o(ctrl), .preload_o(preload), .compare_o(compare),
    .psc_o(psc_val), .flags_o(flags), .rdata_o
  );

  // only the watchdog code runs; reserved and other codes stay idle
  assign active = ctrl.en && (ctrl.mode == MODE_WDOG);
  assign live   = active && !stop_i;
  assign load   = active && !active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      div_q    <= 1'b0;
      dma_req_o <= 1'b0;
    end else begin
      active_q  <= active;
      div_q     <= (live && !load) ? ~div_q : 1'b0;
      dma_req_o <= cmp_evt || ovf_evt;
    end
  end

  assign psc_run = live && ctrl.src_psc;

  wdog_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk_i, .rst_ni, .run_i(psc_run), .reload_i(psc_val), .tick_o(psc_tick)
  );

  assign tick = live && !load && (ctrl.src_psc ? psc_tick : div_q);

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .load_i(load), .tick_i(tick),
    .preload_i(preload), .compare_i(compare),
    .cnt_o(cnt), .cmp_evt_o(cmp_evt), .ovf_evt_o(ovf_evt)
  );

  wdog_pin #(.HOLD(HOLD)) u_pin (
    .clk_i, .rst_ni, .live_i(live), .clr_i(load),
    .evt_i(cmp_evt || ovf_evt), .invert_i(ctrl.invert),
    .oe_o(pin_oe_o), .pin_o(pin_o)
  );

  assign irq_cmp_o = flags[0] && ctrl.cmp_ie;
  assign irq_ovf_o = flags[1] && ctrl.ovf_ie;

  AST_MODE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl.mode != MODE_WDOG |-> !tick); // R9
  AST_STOP_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |-> !tick && !psc_run); // R10
  AST_DMA_ON_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags[0]) |-> dma_req_o); // R8
  AST_WAIT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_i && tick && !ovf_evt |=> cnt == $past(cnt) + CNT_W'(1)); // R10
endmodule

// File: tb/sim_wdog_toggle_timer.sv
module sim_wdog_toggle_timer;
  import wdog_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 24;
  localparam int CNT_W = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic stop_i = 1'b0;
  logic wait_i = 1'b0;
  logic irq_cmp_o, irq_ovf_o, dma_req_o, pin_o, pin_oe_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  wdog_toggle_timer #(.DW(DW), .CNT_W(CNT_W), .PSC_W(21), .HOLD(3)) u0 (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i, .rdata_o,
    .stop_i, .wait_i, .irq_cmp_o, .irq_ovf_o, .dma_req_o, .pin_o, .pin_oe_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // {start, match, src_psc, invert, cmp_ie, prescale, edges to compare}
  localparam int VN = 5;
  localparam logic [42:0] VEC [VN] = '{
    {8'd10,  8'd14,  1'b0, 1'b0, 1'b1, 8'd0, 16'd9},
    {8'd0,   8'd1,   1'b0, 1'b1, 1'b0, 8'd0, 16'd3},
    {8'd100, 8'd103, 1'b1, 1'b0, 1'b1, 8'd3, 16'd12},
    {8'd5,   8'd7,   1'b1, 1'b1, 1'b0, 8'd1, 16'd4},
    {8'd200, 8'd250, 1'b0, 1'b1, 1'b1, 8'd0, 16'd101}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // called at a negedge; write takes effect on the next posedge
  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    wr_i = 1'b1; addr_i = a; wdata_i = d[DW-1:0];
    @(posedge clk_i);
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic peek(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    addr_i = a;
    #1;
    d = 32'(rdata_o);
  endtask

  function automatic logic [31:0] ctrl_word(input logic [3:0] mode, input logic src,
      input logic inv, input logic cie, input logic oie, input logic rld);
    return 32'(1) | (32'(mode) << 1) | (32'(src) << 5) | (32'(inv) << 6)
         | (32'(cie) << 7) | (32'(oie) << 8) | (32'(rld) << 9);
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, c0;
    int cyc;
    repeat (3) @(negedge clk_i);
    // R12 reset state
    peek(A_CTRL, v); chk("R12 ctrl", v, 0);
    peek(A_STAT, v); chk("R12 status", v, 0);
    peek(A_CNT, v);  chk("R12 count", v, 0);
    chk("R12 oe", 32'(pin_oe_o), 0);
    chk("R12 dma", 32'(dma_req_o), 0);
    chk("R12 irq", {30'd0, irq_ovf_o, irq_cmp_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // vector table: R1 R2 R3 R6 R8 R11
    for (int i = 0; i < VN; i++) begin
      logic [7:0] n, m, p;
      logic src, inv, ie;
      logic [15:0] exp_e;
      {n, m, src, inv, ie, p, exp_e} = VEC[i];
      wr(A_CTRL, 0);
      wr(A_STAT, 3);
      wr(A_PRE, 32'(n));
      wr(A_CMP, 32'(m));
      wr(A_PSC, 32'(p));
      repeat (5) @(negedge clk_i);
      chk("R7 released when idle", 32'(pin_oe_o), 0);
      wr(A_CTRL, ctrl_word(MODE_WDOG, src, inv, ie, 1'b0, 1'b0));
      chk("R6 float before first event", 32'(pin_oe_o), 0);
      cyc = 0;
      while (dma_req_o !== 1'b1 && cyc < 3000) begin
        @(posedge clk_i);
        cyc++;
        @(negedge clk_i);
        if (cyc == 1) begin
          peek(A_CNT, v); chk("R2 start loaded", v, 32'(n));
        end
      end
      chk("R1 R11 edges to compare", 32'(cyc), 32'(exp_e));
      peek(A_STAT, v); chk("R3 compare flag", v, 1);
      peek(A_CNT, v);  chk("R2 count at match", v, 32'(m));
      chk("R3 irq mask", 32'(irq_cmp_o), 32'(ie));
      chk("R6 pin enable", 32'(pin_oe_o), 1);
      chk("R6 pin level", 32'(pin_o), 32'(inv));
      @(negedge clk_i);
      chk("R8 single pulse", 32'(dma_req_o), 0);
    end

    // R4 wrap with reload bit set
    wr(A_CTRL, 0); wr(A_STAT, 3);
    wr(A_PRE, 250); wr(A_CMP, 5);
    wr(A_CTRL, ctrl_word(MODE_WDOG, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1));
    cyc = 0;
    while (dma_req_o !== 1'b1 && cyc < 3000) begin
      @(posedge clk_i); cyc++; @(negedge clk_i);
    end
    chk("R4 edges to wrap", 32'(cyc), 13);
    peek(A_STAT, v); chk("R4 wrap flag", v, 2);
    peek(A_CNT, v);  chk("R4 reload start", v, 250);
    chk("R4 irq_ovf", 32'(irq_ovf_o), 1);
    chk("R4 no irq_cmp", 32'(irq_cmp_o), 0);
    wr(A_STAT, 2);
    peek(A_STAT, v); chk("R5 clear wrap flag", v, 0);
    chk("R5 irq_ovf cleared", 32'(irq_ovf_o), 0);

    // R5 clear on the same edge as a compare
    wr(A_CTRL, 0); wr(A_STAT, 3);
    wr(A_PRE, 0); wr(A_CMP, 2);
    wr(A_CTRL, ctrl_word(MODE_WDOG, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0));
    repeat (4) @(negedge clk_i);
    wr(A_STAT, 1);
    peek(A_STAT, v); chk("R5 event beats clear", v, 1);
    chk("R8 dma with coincident clear", 32'(dma_req_o), 1);
    wr(A_STAT, 1);
    peek(A_STAT, v); chk("R5 plain clear", v, 0);

    // R7 R10 stop: hold then release, count frozen
    chk("R6 driving before stop", 32'(pin_oe_o), 1);
    stop_i = 1'b1;
    #1; chk("R7 hold cycle 0", 32'(pin_oe_o), 1);
    @(negedge clk_i); chk("R7 hold cycle 1", 32'(pin_oe_o), 1);
    @(negedge clk_i); chk("R7 hold cycle 2", 32'(pin_oe_o), 1);
    @(negedge clk_i); chk("R7 released", 32'(pin_oe_o), 0);
    peek(A_CNT, c0);
    repeat (20) @(negedge clk_i);
    peek(A_CNT, v); chk("R10 count frozen in stop", v, c0);
    stop_i = 1'b0;
    repeat (10) @(negedge clk_i);
    peek(A_CNT, v); chk("R10 resume after stop", v, c0 + 5);
    chk("R10 pin driven again", 32'(pin_oe_o), 1);
    wait_i = 1'b1;
    peek(A_CNT, c0);
    repeat (10) @(negedge clk_i);
    peek(A_CNT, v); chk("R10 wait has no effect", v, c0 + 5);
    wait_i = 1'b0;

    // R9 reserved mode codes stay idle
    foreach (VEC[k]) begin end
    for (int j = 0; j < 6; j++) begin
      logic [3:0] md;
      md = (j == 0) ? 4'd8 : 4'(10 + j);
      wr(A_CTRL, 0); wr(A_STAT, 3);
      wr(A_PRE, 77);
      wr(A_CTRL, ctrl_word(md, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0));
      peek(A_CNT, c0);
      repeat (30) @(negedge clk_i);
      peek(A_CNT, v); chk("R9 reserved mode count idle", v, c0);
      peek(A_STAT, v); chk("R9 reserved mode no flags", v, 0);
      chk("R9 reserved mode pin float", 32'(pin_oe_o), 0);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule